// File: doc/BRIEF.md
# Multiplexed Seven-Segment LED Scan Driver

This block lights a common-anode seven-segment display of up to five digits with one set of eight segment lines. It switches the digits on one after another and drives each digit's segments only while that digit's common line is active. A clock-enable pulse (`tick_i`) from an external prescaler paces the scan. Configuration inputs set how many digits are scanned, how long each digit's slot lasts, how bright the display looks, whether the display is shown at all and whether the block is enabled. Each digit also has its own 8-bit segment pattern.

Every digit owns a slot of `4*(period_i+1)+1` ticks. The first tick of each slot is dark on all outputs, so no segment pattern is ever shown on the wrong digit. The rest of the slot is split into four equal quarters, and the brightness code picks how many quarters are lit. The slot length does not depend on brightness, so a change of brightness never changes the refresh rate. Pad drive strength and current limiting are left to the chip's I/O ring.

Top module: `seg7_scan_top`

## Requirements
- R1: While reset is asserted and right after it is released, `seg_o` and `com_o` are all zero.
- R2: A digit slot lasts `4*(period_i+1)+1` ticks of `tick_i`. Digits are scanned in the order 0, 1, ... up to the last enabled digit and then back to 0. While digit k is lit, `com_o` is one-hot with bit k set (1 = anode powered).
- R3: While `com_o[k]` is 1, `seg_o` equals `pattern_i[8k+7:8k]`, where a 1 lights a segment and bit 7 is the decimal point. While `com_o` is zero, `seg_o` is zero.
- R4: Slot position 0, the first tick of every slot, is dark on all outputs.
- R5: Brightness code c (`bright_i`, 0..3) lights slot positions 1 to `(4-c)*(period_i+1)`, so code 0 lights the whole slot after the blank tick, code 1 lights 3/4, code 2 lights 1/2 and code 3 lights 1/4. The slot length does not change with c.
- R6: `dig_cnt_i` = n enables digits 0..min(n,4). The common outputs of digits above that range stay 0, and their pattern bytes have no effect on the outputs.
- R7: If `mod_en_i` is 0 (including the illegal setting `disp_on_i`=1 with `mod_en_i`=0) or `disp_on_i` is 0, all outputs are 0.
- R8: The digit index and the slot position restart at 0 when the display starts running, and also when the value of `dig_cnt_i` changes.
- R9: The scan advances only on cycles where `tick_i` is 1. With stable inputs and no tick, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan clock enable from the prescaler |
| mod_en_i | input | 1 | Module enable |
| disp_on_i | input | 1 | Display on |
| dig_cnt_i | input | 3 | Highest digit index to scan (values above 4 are treated as 4) |
| period_i | input | 8 | Slot length divider |
| bright_i | input | 2 | Brightness code |
| pattern_i | input | 40 | Segment pattern per digit, digit k in bits 8k+7:8k |
| seg_o | output | 8 | Segment drive, 1 = lit, bit 7 = decimal point |
| com_o | output | 5 | Common anode drive, 1 = digit powered |

## Verification
The bench uses the default parameters: five digits, eight segments, a 3-bit count and an 8-bit divider. With these, every count value is reachable, including the values 5 to 7 that are clamped to five digits. Short periods (0 and 1) keep a whole scan of several digits within a few dozen ticks. That makes the blank tick, the quarter boundaries of every brightness code, the wrap from the last digit back to digit 0 and restarts in the middle of a slot all cheap to visit tick by tick.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

   // number of equal parts a lit window is cut into
   localparam int unsigned QUARTERS = 4;
   localparam int unsigned LVL_W    = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_FULL  = 2'd0,
      LVL_3Q    = 2'd1,
      LVL_HALF  = 2'd2,
      LVL_1Q    = 2'd3
   } level_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/seg7_slot_timer.sv
// Slot position counter and lit-window decode for one digit slot.
module seg7_slot_timer
   import seg7_pkg::*;
#(
   parameter int unsigned DIV_W = 8,
   parameter int unsigned POS_W = DIV_W + 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] period_i,
   input  level_e           level_i,
   output logic             wrap_o,
   output logic             lit_o
);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] unit_len;
   logic [POS_W-1:0] slot_last;
   logic [POS_W-1:0] on_end;

   always_comb begin
      unit_len  = POS_W'(period_i) + POS_W'(1);
      slot_last = unit_len << 2;
      unique case (level_i)
         LVL_FULL: on_end = unit_len << 2;
         LVL_3Q:   on_end = (unit_len << 1) + unit_len;
         LVL_HALF: on_end = unit_len << 1;
         default:  on_end = unit_len;
      endcase
   end

   // >= keeps the counter sane if the period shrinks mid-slot
   assign wrap_o = tick_i && (pos_q >= slot_last);
   assign lit_o  = (pos_q != '0) && (pos_q <= on_end);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
      end else if (restart_i) begin
         pos_q <= '0;
      end else if (tick_i) begin
         if (pos_q >= slot_last) pos_q <= '0;
         else                    pos_q <= pos_q + POS_W'(1);
      end
   end

endmodule

// File: rtl/seg7_digit_seq.sv
// Digit index sequencer: steps through 0..last_i and wraps.
module seg7_digit_seq #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             advance_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [IDX_W-1:0] dig_o
);

   logic [IDX_W-1:0] dig_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dig_q <= '0;
      end else if (restart_i) begin
         dig_q <= '0;
      end else if (advance_i) begin
         if (dig_q >= last_i) dig_q <= '0;
         else                 dig_q <= dig_q + IDX_W'(1);
      end
   end

   assign dig_o = dig_q;

endmodule

// File: rtl/seg7_out_stage.sv
// Common decode and segment pattern select, gated by run and lit window.
module seg7_out_stage #(
   parameter int unsigned NUM_DIGITS = 5,
   parameter int unsigned SEG_W      = 8,
   parameter int unsigned IDX_W      = 3
) (
   input  logic                        run_i,
   input  logic                        lit_i,
   input  logic [IDX_W-1:0]            dig_i,
   input  logic [NUM_DIGITS*SEG_W-1:0] pattern_i,
   output logic [SEG_W-1:0]            seg_o,
   output logic [NUM_DIGITS-1:0]       com_o
);

   logic [SEG_W-1:0]      pat_arr [NUM_DIGITS];
   logic [NUM_DIGITS-1:0] hit;
   logic                  show;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      assign pat_arr[k] = pattern_i[k*SEG_W +: SEG_W];
      assign hit[k]     = (dig_i == IDX_W'(k));
   end

   assign show  = run_i && lit_i;
   assign com_o = show ? hit : '0;

   always_comb begin
      seg_o = '0;
      for (int k = 0; k < NUM_DIGITS; k++) begin
         if (show && hit[k]) seg_o = pat_arr[k];
      end
   end

endmodule

// File: rtl/seg7_scan_top.sv
module seg7_scan_top
   import seg7_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 5,
   parameter int unsigned SEG_W      = 8,
   parameter int unsigned CNT_W      = 3,
   parameter int unsigned DIV_W      = 8
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        tick_i,
   input  logic                        mod_en_i,
   input  logic                        disp_on_i,
   input  logic [CNT_W-1:0]            dig_cnt_i,
   input  logic [DIV_W-1:0]            period_i,
   input  logic [LVL_W-1:0]            bright_i,
   input  logic [NUM_DIGITS*SEG_W-1:0] pattern_i,
   output logic [SEG_W-1:0]            seg_o,
   output logic [NUM_DIGITS-1:0]       com_o
);

   localparam int unsigned IDX_W = idx_width(NUM_DIGITS);
   localparam int unsigned POS_W = DIV_W + 3;

   if (NUM_DIGITS < 1 || NUM_DIGITS > (1 << CNT_W)) begin : g_bad_digits
      $error("NUM_DIGITS must be 1..2**CNT_W");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic             run;
   logic             restart;
   logic             wrap;
   logic             lit;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] dig_idx;

   // illegal display-on with module disabled falls out as not running
   assign run = mod_en_i && disp_on_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= dig_cnt_i;
   end

   // stopped, or count changed: hold everything at digit 0, position 0
   assign restart = !run || (dig_cnt_i != cnt_q);

   always_comb begin
      if (dig_cnt_i >= CNT_W'(NUM_DIGITS - 1)) last_idx = IDX_W'(NUM_DIGITS - 1);
      else                                     last_idx = IDX_W'(dig_cnt_i);
   end

   seg7_slot_timer #(
      .DIV_W (DIV_W),
      .POS_W (POS_W)
   ) i_slot_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .tick_i    (tick_i),
      .period_i  (period_i),
      .level_i   (level_e'(bright_i)),
      .wrap_o    (wrap),
      .lit_o     (lit)
   );

   seg7_digit_seq #(
      .IDX_W (IDX_W)
   ) i_digit_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .advance_i (wrap),
      .last_i    (last_idx),
      .dig_o     (dig_idx)
   );

   seg7_out_stage #(
      .NUM_DIGITS (NUM_DIGITS),
      .SEG_W      (SEG_W),
      .IDX_W      (IDX_W)
   ) i_out_stage (
      .run_i     (run),
      .lit_i     (lit),
      .dig_i     (dig_idx),
      .pattern_i (pattern_i),
      .seg_o     (seg_o),
      .com_o     (com_o)
   );

endmodule

// File: rtl/seg7_scan_chk.sv
module seg7_scan_chk #(
   parameter int unsigned NUM_DIGITS = 5,
   parameter int unsigned SEG_W      = 8,
   parameter int unsigned IDX_W      = 3
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        mod_en_i,
   input logic                        disp_on_i,
   input logic [NUM_DIGITS*SEG_W-1:0] pattern_i,
   input logic [SEG_W-1:0]            seg_o,
   input logic [NUM_DIGITS-1:0]       com_o,
   input logic [IDX_W-1:0]            dig_q,
   input logic [IDX_W-1:0]            last_i
);

   // R2
   com_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(com_o));

   // R7
   dark_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mod_en_i && disp_on_i) |-> (com_o == '0 && seg_o == '0));

   // R3
   seg_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (com_o == '0) |-> (seg_o == '0));

   // R4
   blank_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (com_o != '0 && $past(com_o) != '0) |-> (com_o == $past(com_o)));

   // R6
   digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(last_i) |-> (dig_q <= last_i));

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_map
      // R3
      seg_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         com_o[k] |-> (seg_o == pattern_i[k*SEG_W +: SEG_W]));
   end

endmodule

bind seg7_scan_top seg7_scan_chk #(
   .NUM_DIGITS (NUM_DIGITS),
   .SEG_W      (SEG_W),
   .IDX_W      (IDX_W)
) i_seg7_scan_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .mod_en_i  (mod_en_i),
   .disp_on_i (disp_on_i),
   .pattern_i (pattern_i),
   .seg_o     (seg_o),
   .com_o     (com_o),
   .dig_q     (dig_idx),
   .last_i    (last_idx)
);

// File: tb/test_seg7_scan_top.sv
module test_seg7_scan_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        mod_en = 1'b0;
   logic        disp_on = 1'b0;
   logic [2:0]  dcnt = 3'd0;
   logic [7:0]  per = 8'd0;
   logic [1:0]  lvl = 2'd0;
   logic [39:0] pat = 40'h0;
   logic [7:0]  seg_o;
   logic [4:0]  com_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   seg7_scan_top i_seg7_scan_top (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .mod_en_i  (mod_en),
      .disp_on_i (disp_on),
      .dig_cnt_i (dcnt),
      .period_i  (per),
      .bright_i  (lvl),
      .pattern_i (pat),
      .seg_o     (seg_o),
      .com_o     (com_o)
   );

   // expected outputs n ticks after a restart, from the requirements
   task automatic model(input int n, output logic [7:0] es, output logic [4:0] ec);
      int nd, slot, pos, d;
      bit on;
      nd   = (int'(dcnt) > 4) ? 5 : int'(dcnt) + 1;
      slot = 4 * (int'(per) + 1) + 1;
      pos  = n % slot;
      d    = (n / slot) % nd;
      on   = (pos >= 1) && (pos <= (4 - int'(lvl)) * (int'(per) + 1));
      es   = on ? pat[d*8 +: 8] : 8'h00;
      ec   = on ? (5'b00001 << d) : 5'b00000;
   endtask

   task automatic check(input string req, input logic [7:0] es, input logic [4:0] ec);
      n_chk++;
      if (seg_o !== es || com_o !== ec) begin
         n_bad++;
         $display("FAIL %s: seg=%h com=%b, expected seg=%h com=%b", req, seg_o, com_o, es, ec);
      end
   endtask

   task automatic check_model(input string req, input int n);
      logic [7:0] es;
      logic [4:0] ec;
      model(n, es, ec);
      check(req, es, ec);
   endtask

   task automatic one_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   // stop, configure, start; leaves the block at tick count 0
   task automatic start(input logic [2:0] c, input logic [7:0] p, input logic [1:0] l);
      @(negedge clk);
      disp_on = 1'b0;
      @(negedge clk);
      mod_en = 1'b1; dcnt = c; per = p; lvl = l; disp_on = 1'b1;
      @(negedge clk);
   endtask

   task automatic scan(input string req, input int nticks);
      check_model(req, 0);
      for (int n = 1; n <= nticks; n++) begin
         one_tick();
         check_model(req, n);
      end
   endtask

   task automatic t_reset();
      mod_en = 1'b1; disp_on = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 in reset", 8'h00, 5'b00000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 8'h00, 5'b00000);
   endtask

   task automatic t_basic();
      pat = 40'h5A_3C_F0_0F_A5;
      start(3'd2, 8'd0, 2'd0);
      scan("R2 R3 R4 basic 3 digits", 30);
   endtask

   task automatic t_decimal_point();
      pat = 40'h11_22_33_44_80;
      start(3'd1, 8'd0, 2'd0);
      one_tick();
      // R3: bit 7 of digit 0 pattern is the decimal point
      check("R3 decimal point", 8'h80, 5'b00001);
   endtask

   task automatic t_bright();
      pat = 40'h01_02_04_08_10;
      for (int l = 1; l < 4; l++) begin
         int lit_cnt;
         start(3'd1, 8'd1, 2'(l));
         scan("R5 brightness scan", 2 * 9 + 3);
         // R5: count lit ticks over one full slot of the next run
         start(3'd1, 8'd1, 2'(l));
         lit_cnt = 0;
         for (int n = 1; n <= 9; n++) begin
            one_tick();
            if (com_o != 5'b0) lit_cnt++;
         end
         n_chk++;
         if (lit_cnt != (4 - l) * 2) begin
            n_bad++;
            $display("FAIL R5 lit ticks code %0d: %0d, expected %0d", l, lit_cnt, (4 - l) * 2);
         end
         // R5: next digit lights on the tick after the 9-tick slot
         one_tick();
         check("R5 slot length unchanged", pat[15:8], 5'b00010);
      end
   endtask

   task automatic t_count();
      pat = 40'hC1_B2_A3_94_85;
      start(3'd7, 8'd0, 2'd0);
      scan("R6 count 7 clamps to five digits", 30);
      start(3'd0, 8'd0, 2'd0);
      scan("R6 single digit", 6);
      @(negedge clk) pat[15:8] = 8'hFF;
      // R6: unused digit's pattern has no effect
      for (int n = 7; n <= 12; n++) begin
         one_tick();
         check_model("R6 unused pattern ignored", n);
      end
   endtask

   task automatic t_off();
      pat = 40'hFF_FF_FF_FF_FF;
      start(3'd4, 8'd0, 2'd0);
      @(negedge clk) mod_en = 1'b0;
      for (int n = 0; n < 12; n++) begin
         one_tick();
         check("R7 display on with module off", 8'h00, 5'b00000);
      end
      @(negedge clk) begin mod_en = 1'b1; disp_on = 1'b0; end
      for (int n = 0; n < 8; n++) begin
         one_tick();
         check("R7 display off", 8'h00, 5'b00000);
      end
   endtask

   task automatic t_restart();
      pat = 40'h0A_0B_0C_0D_0E;
      start(3'd2, 8'd0, 2'd0);
      scan("R8 pre-restart", 7);
      @(negedge clk) disp_on = 1'b0;
      @(negedge clk) disp_on = 1'b1;
      @(negedge clk);
      check("R8 restart on display on, position 0", 8'h00, 5'b00000);
      one_tick();
      check("R8 restart on display on, digit 0", 8'h0E, 5'b00001);
      for (int n = 2; n <= 8; n++) one_tick();
      check_model("R8 before count change", 8);
      @(negedge clk) dcnt = 3'd3;
      @(negedge clk);
      check("R8 restart on count change, position 0", 8'h00, 5'b00000);
      scan("R8 after count change", 25);
   endtask

   task automatic t_hold();
      pat = 40'h21_42_63_84_A5;
      start(3'd2, 8'd0, 2'd0);
      for (int n = 1; n <= 6; n++) one_tick();
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         check_model("R9 no tick holds", 6);
      end
      one_tick();
      check_model("R9 tick advances", 7);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_decimal_point();
      t_bright();
      t_count();
      t_off();
      t_restart();
      t_hold();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule